// File: doc/BRIEF.md
# Security attribution region checker

This block keeps a small table of programmable address windows and sorts every 32-bit address presented to it into one of three security classes: Secure, Non-secure, or Non-secure-callable. A window covers whole 32-byte granules. Its lower bound and its upper bound are both inclusive, and each window carries an enable bit and a callable-entry flag. The lookup is purely combinational. A caller presents an address with a valid strobe and gets back, in the same cycle, the attribute, a hit indication and a flag that says more than one window matched.

Software sets the block up through a small word-addressed register port. A global control word turns the unit on or off. While the unit is off, a single fallback bit decides the class of all memory. Windows are reached indirectly: a selector register names one window, and two further registers then read and write that window's lower bound and its upper bound with flags. A read-only word reports how many windows are built in. When the selector points past the last window, the bound registers read as zero and writes to them are discarded.

Top module: `sec_attr_unit`

## Requirements
- R1: After reset every stored field is zero: the control word, the selector and all window bounds and flags read 0, and any valid lookup returns Secure (attr code 2'b00) with hit low.
- R2: With the control enable (bit 0 of the word at byte offset 0x00) at 0, a valid lookup ignores all windows, keeps hit and multi low, and returns Non-secure (code 2'b01) when control bit 1 is 1 and Secure (code 2'b00) when it is 0.
- R3: The word at offset 0x04 always reads the window count (8 by default) in bits 7:0 with zeros above, and writes to it change nothing.
- R4: The selector at offset 0x08 stores bits 7:0 of the written word, reads back with bits 31:8 zero, and changes only on a write to that offset.
- R5: The lower-bound register at offset 0x0C stores written bits 31:5 for the selected window and reads bits 4:0 as zero.
- R6: The upper-bound register at offset 0x10 stores bits 31:5 and the flags in bit 1 (callable entry) and bit 0 (window enable) for the selected window, and reads bits 4:2 as zero.
- R7: A window matches an address when its enable is 1 and lower[31:5] <= addr[31:5] <= upper[31:5], so the window reaches offset 0x1F of its top granule; a disabled window never matches.
- R8: With the unit enabled, an address matching exactly one window returns hit high, multi low, and Non-secure (2'b01) if that window's callable flag is 0 or Non-secure-callable (2'b10) if it is 1; an address matching no window returns Secure with hit low. Code 2'b11 is never produced.
- R9: With the unit enabled, an address matching two or more windows returns Secure with both hit and multi high.
- R10: When the selector is at or above the window count, the bound registers read as zero and writes to them leave every window unchanged.
- R11: While the lookup valid strobe is low, the outputs are Secure with hit and multi low.
- R12: The control word stores bits 1:0 and reads bits 31:2 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register state |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte offset of the register; bits 4:2 pick the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Address to classify |
| lk_attr | output | 2 | Class: 00 Secure, 01 Non-secure, 10 Non-secure-callable |
| lk_hit | output | 1 | At least one enabled window matched |
| lk_multi | output | 1 | Two or more enabled windows matched |

## Verification
Lookups probe the first and last byte of a window and the bytes just outside it, which tells an inclusive granule compare from an exclusive or byte-exact one. Addresses inside a lone Non-secure window, a lone callable window, the overlap of two windows and a disabled window separate the per-flag encoding, the multi-hit override and the enable gate. The same programmed table is then looked up with the unit switched off under both fallback settings, which shows that windows are ignored rather than merely overridden. Register traffic with the selector past the last window, followed by reading a real window, shows that dropped writes did not alias onto a valid entry.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

   typedef enum logic [1:0] {
      ATTR_S   = 2'b00,
      ATTR_NS  = 2'b01,
      ATTR_NSC = 2'b10
   } sec_attr_e;

   // word index of each register, taken from reg_addr[4:2]
   localparam logic [2:0] WI_CTRL  = 3'd0;
   localparam logic [2:0] WI_COUNT = 3'd1;
   localparam logic [2:0] WI_SEL   = 3'd2;
   localparam logic [2:0] WI_LOWER = 3'd3;
   localparam logic [2:0] WI_UPPER = 3'd4;

endpackage

// File: rtl/sec_attr_regs.sv
module sec_attr_regs
   import sec_attr_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 32,
   parameter int GLSB = 5,
   localparam int RW  = AW - GLSB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [4:0]               addr,
   input  logic [31:0]              wdata,
   output logic [31:0]              rdata,
   output logic                     unit_en,
   output logic                     all_ns,
   output logic [7:0]               sel,
   output logic [NREG-1:0][RW-1:0]  lower,
   output logic [NREG-1:0][RW-1:0]  upper,
   output logic [NREG-1:0]          win_en,
   output logic [NREG-1:0]          win_nsc
);

   localparam int         IW      = (NREG > 1) ? $clog2(NREG) : 1;
   localparam logic [7:0] COUNT_B = 8'(NREG);

   logic [2:0]    widx;
   logic          sel_ok;
   logic [IW-1:0] sel_idx;

   assign widx    = addr[4:2];
   assign sel_ok  = (32'(sel) < NREG);
   assign sel_idx = sel[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_en <= 1'b0;
         all_ns  <= 1'b0;
         sel     <= '0;
         lower   <= '0;
         upper   <= '0;
         win_en  <= '0;
         win_nsc <= '0;
      end else if (wr_en) begin
         case (widx)
            WI_CTRL: begin
               unit_en <= wdata[0];
               all_ns  <= wdata[1];
            end
            WI_SEL: sel <= wdata[7:0];
            WI_LOWER: begin
               if (sel_ok) lower[sel_idx] <= wdata[AW-1:GLSB];
            end
            WI_UPPER: begin
               if (sel_ok) begin
                  upper[sel_idx]   <= wdata[AW-1:GLSB];
                  win_nsc[sel_idx] <= wdata[1];
                  win_en[sel_idx]  <= wdata[0];
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (widx)
         WI_CTRL:  rdata[1:0] = {all_ns, unit_en};
         WI_COUNT: rdata[7:0] = COUNT_B;
         WI_SEL:   rdata[7:0] = sel;
         WI_LOWER: begin
            if (sel_ok) rdata[AW-1:GLSB] = lower[sel_idx];
         end
         WI_UPPER: begin
            if (sel_ok) begin
               rdata[AW-1:GLSB] = upper[sel_idx];
               rdata[1]         = win_nsc[sel_idx];
               rdata[0]         = win_en[sel_idx];
            end
         end
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/sec_attr_match.sv
module sec_attr_match #(
   parameter int NREG = 8,
   parameter int AW   = 32,
   parameter int GLSB = 5,
   localparam int RW  = AW - GLSB
) (
   input  logic [AW-1:0]            addr,
   input  logic [NREG-1:0][RW-1:0]  lower,
   input  logic [NREG-1:0][RW-1:0]  upper,
   input  logic [NREG-1:0]          win_en,
   output logic [NREG-1:0]          hits
);

   logic [RW-1:0] granule;
   assign granule = addr[AW-1:GLSB];

   for (genvar i = 0; i < NREG; i++) begin : g_win
      logic above_lo;
      logic below_hi;
      assign above_lo = (granule >= lower[i]);
      assign below_hi = (granule <= upper[i]);
      assign hits[i]  = win_en[i] & above_lo & below_hi;
   end

endmodule

// File: rtl/sec_attr_resolve.sv
module sec_attr_resolve
   import sec_attr_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic            valid,
   input  logic            unit_en,
   input  logic            all_ns,
   input  logic [NREG-1:0] hits,
   input  logic [NREG-1:0] win_nsc,
   output sec_attr_e       attr,
   output logic            hit,
   output logic            multi
);

   logic any_hit;
   logic many_hit;
   logic nsc_hit;

   assign any_hit = |hits;
   assign nsc_hit = |(hits & win_nsc);

   // clearing the lowest set bit leaves something only if two or more were set
   if (NREG > 1) begin : g_many
      assign many_hit = |(hits & (hits - NREG'(1)));
   end else begin : g_single
      assign many_hit = 1'b0;
   end

   always_comb begin
      attr  = ATTR_S;
      hit   = 1'b0;
      multi = 1'b0;
      if (valid) begin
         if (!unit_en) begin
            attr = all_ns ? ATTR_NS : ATTR_S;
         end else begin
            hit   = any_hit;
            multi = many_hit;
            if (any_hit && !many_hit) attr = nsc_hit ? ATTR_NSC : ATTR_NS;
         end
      end
   end

endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
   import sec_attr_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 32,
   parameter int GLSB = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [4:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        lk_valid,
   input  logic [31:0] lk_addr,
   output logic [1:0]  lk_attr,
   output logic        lk_hit,
   output logic        lk_multi
);

   localparam int RW = AW - GLSB;

   if (NREG < 1 || NREG > 255) begin : g_bad_nreg
      $error("sec_attr_unit: NREG must lie in 1..255");
   end
   if (AW != 32) begin : g_bad_aw
      $error("sec_attr_unit: AW must be 32");
   end
   if (GLSB < 2 || GLSB > 12) begin : g_bad_glsb
      $error("sec_attr_unit: GLSB must lie in 2..12");
   end

   logic                    en_w;
   logic                    allns_w;
   logic [7:0]              sel_w;
   logic [NREG-1:0][RW-1:0] lower_w;
   logic [NREG-1:0][RW-1:0] upper_w;
   logic [NREG-1:0]         wen_w;
   logic [NREG-1:0]         wnsc_w;
   logic [NREG-1:0]         hits_w;
   sec_attr_e               attr_w;

   sec_attr_regs #(.NREG(NREG), .AW(AW), .GLSB(GLSB)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .unit_en (en_w),
      .all_ns  (allns_w),
      .sel     (sel_w),
      .lower   (lower_w),
      .upper   (upper_w),
      .win_en  (wen_w),
      .win_nsc (wnsc_w)
   );

   sec_attr_match #(.NREG(NREG), .AW(AW), .GLSB(GLSB)) match_i (
      .addr   (lk_addr),
      .lower  (lower_w),
      .upper  (upper_w),
      .win_en (wen_w),
      .hits   (hits_w)
   );

   sec_attr_resolve #(.NREG(NREG)) resolve_i (
      .valid   (lk_valid),
      .unit_en (en_w),
      .all_ns  (allns_w),
      .hits    (hits_w),
      .win_nsc (wnsc_w),
      .attr    (attr_w),
      .hit     (lk_hit),
      .multi   (lk_multi)
   );

   assign lk_attr = attr_w;

endmodule

// File: rtl/sec_attr_unit_chk.sv
module sec_attr_unit_chk #(
   parameter int NREG = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_en,
   input logic [4:0]  reg_addr,
   input logic [31:0] reg_rdata,
   input logic        en_w,
   input logic        allns_w,
   input logic [7:0]  sel_w,
   input logic        lk_valid,
   input logic [1:0]  lk_attr,
   input logic        lk_hit,
   input logic        lk_multi
);

   localparam logic [1:0] C_S   = 2'b00;
   localparam logic [1:0] C_NS  = 2'b01;

   assert_disabled_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !en_w) |-> (!lk_hit && !lk_multi && lk_attr == (allns_w ? C_NS : C_S)));

   assert_count_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[4:2] == 3'd1) |-> (reg_rdata == 32'(NREG)));

   assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |=> $stable(sel_w));

   assert_single_not_secure_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_multi) |-> (lk_attr != C_S));

   assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_attr != 2'b11);

   assert_multi_secure_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> (lk_hit && lk_attr == C_S));

   assert_oor_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(sel_w) >= NREG) && (reg_addr[4:2] == 3'd3 || reg_addr[4:2] == 3'd4))
      |-> (reg_rdata == 32'd0));

   assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (lk_attr == C_S && !lk_hit && !lk_multi));

   assert_ctrl_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[4:2] == 3'd0) |-> (reg_rdata[31:2] == 30'd0));

endmodule

bind sec_attr_unit sec_attr_unit_chk #(.NREG(NREG)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .en_w      (en_w),
   .allns_w   (allns_w),
   .sel_w     (sel_w),
   .lk_valid  (lk_valid),
   .lk_attr   (lk_attr),
   .lk_hit    (lk_hit),
   .lk_multi  (lk_multi)
);

// File: tb/sec_attr_unit_tb.sv
module sec_attr_unit_tb_top;

   localparam logic [4:0] A_CTRL  = 5'h00;
   localparam logic [4:0] A_COUNT = 5'h04;
   localparam logic [4:0] A_SEL   = 5'h08;
   localparam logic [4:0] A_LOWER = 5'h0C;
   localparam logic [4:0] A_UPPER = 5'h10;
   localparam logic [1:0] S   = 2'b00;
   localparam logic [1:0] NS  = 2'b01;
   localparam logic [1:0] NSC = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic [1:0]  lk_attr;
   logic        lk_hit;
   logic        lk_multi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sec_attr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .lk_attr(lk_attr), .lk_hit(lk_hit), .lk_multi(lk_multi)
   );

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", req, a, reg_rdata, exp);
      end
   endtask

   task automatic lk_chk(input logic v, input logic [31:0] a, input logic [1:0] ea,
                         input logic eh, input logic em, input string req);
      @(negedge clk);
      lk_valid = v; lk_addr = a;
      #1;
      checks++;
      if (lk_attr !== ea || lk_hit !== eh || lk_multi !== em) begin
         errors++;
         $display("FAIL %s: addr 0x%08h got attr=%0d hit=%0d multi=%0d expected attr=%0d hit=%0d multi=%0d",
                  req, a, lk_attr, lk_hit, lk_multi, ea, eh, em);
      end
      lk_valid = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk(A_CTRL, 32'h0, "R1");
      rd_chk(A_SEL, 32'h0, "R1");
      rd_chk(A_LOWER, 32'h0, "R1");
      rd_chk(A_UPPER, 32'h0, "R1");
      lk_chk(1'b1, 32'h1234_5678, S, 1'b0, 1'b0, "R1");
   endtask

   task automatic t_ctrl;
      wr(A_CTRL, 32'hFFFF_FFFC);
      rd_chk(A_CTRL, 32'h0, "R12");
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd_chk(A_CTRL, 32'h3, "R12");
      wr(A_CTRL, 32'h2);
      lk_chk(1'b1, 32'h0000_0040, NS, 1'b0, 1'b0, "R2");
      wr(A_CTRL, 32'h0);
      lk_chk(1'b1, 32'h0000_0040, S, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_count;
      rd_chk(A_COUNT, 32'd8, "R3");
      wr(A_COUNT, 32'h0000_0055);
      rd_chk(A_COUNT, 32'd8, "R3");
   endtask

   task automatic t_sel;
      wr(A_SEL, 32'h0000_01A5);
      rd_chk(A_SEL, 32'h0000_00A5, "R4");
      wr(A_SEL, 32'h0);
      rd_chk(A_SEL, 32'h0, "R4");
   endtask

   task automatic t_windows;
      // window 0: 0x20000000..0x200000FF, Non-secure
      wr(A_SEL, 32'd0);
      wr(A_LOWER, 32'h2000_001F);
      rd_chk(A_LOWER, 32'h2000_0000, "R5");
      wr(A_UPPER, 32'h2000_00FD);
      rd_chk(A_UPPER, 32'h2000_00E1, "R6");
      // window 1: callable
      wr(A_SEL, 32'd1);
      wr(A_LOWER, 32'h3000_0000);
      wr(A_UPPER, 32'h3000_0003);
      rd_chk(A_UPPER, 32'h3000_0003, "R6");
      // window 2: overlaps window 0 from 0x20000080
      wr(A_SEL, 32'd2);
      wr(A_LOWER, 32'h2000_0080);
      wr(A_UPPER, 32'h2000_0FE1);
      // window 3: programmed but disabled
      wr(A_SEL, 32'd3);
      wr(A_LOWER, 32'h4000_0000);
      wr(A_UPPER, 32'h4000_0002);
      wr(A_CTRL, 32'h1);
      lk_chk(1'b1, 32'h2000_0000, NS, 1'b1, 1'b0, "R7");
      lk_chk(1'b1, 32'h2000_007F, NS, 1'b1, 1'b0, "R7");
      lk_chk(1'b1, 32'h1FFF_FFFF, S, 1'b0, 1'b0, "R7");
      lk_chk(1'b1, 32'h2000_0FFF, NS, 1'b1, 1'b0, "R7");
      lk_chk(1'b1, 32'h2000_1000, S, 1'b0, 1'b0, "R8");
      lk_chk(1'b1, 32'h4000_0010, S, 1'b0, 1'b0, "R7");
      lk_chk(1'b1, 32'h3000_0010, NSC, 1'b1, 1'b0, "R8");
      lk_chk(1'b1, 32'h3000_001F, NSC, 1'b1, 1'b0, "R8");
      lk_chk(1'b1, 32'h2000_0080, S, 1'b1, 1'b1, "R9");
      lk_chk(1'b1, 32'h2000_00FF, S, 1'b1, 1'b1, "R9");
      lk_chk(1'b1, 32'h2000_0100, NS, 1'b1, 1'b0, "R8");
   endtask

   task automatic t_out_of_range;
      wr(A_SEL, 32'd8);
      wr(A_LOWER, 32'h5000_0000);
      wr(A_UPPER, 32'h5000_0001);
      rd_chk(A_LOWER, 32'h0, "R10");
      rd_chk(A_UPPER, 32'h0, "R10");
      lk_chk(1'b1, 32'h5000_0000, S, 1'b0, 1'b0, "R10");
      wr(A_SEL, 32'd0);
      rd_chk(A_LOWER, 32'h2000_0000, "R10");
      rd_chk(A_UPPER, 32'h2000_00E1, "R10");
   endtask

   task automatic t_idle_and_off;
      lk_chk(1'b0, 32'h3000_0010, S, 1'b0, 1'b0, "R11");
      lk_chk(1'b0, 32'h2000_0080, S, 1'b0, 1'b0, "R11");
      wr(A_CTRL, 32'h0);
      lk_chk(1'b1, 32'h3000_0010, S, 1'b0, 1'b0, "R2");
      wr(A_CTRL, 32'h2);
      lk_chk(1'b1, 32'h2000_0080, NS, 1'b0, 1'b0, "R2");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_count();
      t_sel();
      t_windows();
      t_out_of_range();
      t_idle_and_off();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got running expected finished");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule